// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing register set of a byte-wide UART. It decodes a 64-byte window on a simple single-cycle read/write bus with byte data. Through it software sets up two mode bytes, enables, disables and resets the transmitter and receiver, loads a transmit holding byte, drains the receive FIFO, reads status, and masks the interrupt sources onto one interrupt line.

On the serial side the block hands one byte at a time to a serialiser with a one-cycle strobe. It reads the occupancy of a companion receive FIFO and pops or flushes it. It also takes a break-detect pulse. Bit timing, baud generation, parity and framing are handled elsewhere. The two baud divider bytes come in as inputs and are only read back.

A bus request is taken on the clock edge where `req_i` is high. Read data appears on `rdata_o` after that edge. Register effects take hold at that edge. The interrupt line follows one cycle later.

Top module: `uart_regs`

## Requirements
- R1: After reset the status byte reads 0x08, meaning only the transmitter-empty flag is set. Both mode bytes, the interrupt status, the mask, the mode pointer and both enables are zero, and `irq_o` is low.
- R2: Offset 0x00 accesses the mode byte chosen by a pointer. A write stores into the chosen byte and then points the pointer at the second byte. Command misc code 1 points it back at the first byte.
- R3: The offset is the address modulo 0x40. Writes to offset 0x04 are ignored. Offset 0x18 reads `baud_hi_i` and offset 0x1C reads `baud_lo_i`. Offsets 0x08 and 0x10, and any other unlisted offset, read 0.
- R4: Status bit 0 is receive-ready (the FIFO is not empty). Bit 1 is FIFO-full. Bit 2 is transmit-ready, which equals the transmitter enable. Bit 3 is transmitter-empty. Bits 7 to 4 are always 0.
- R5: A write to offset 0x0C while the transmitter is enabled raises `tx_strobe_o` for one cycle with that byte on `tx_data_o`. Transmitter-empty stays set.
- R6: A write to offset 0x0C while the transmitter is disabled clears transmitter-empty and holds the byte. A later write replaces the held byte. A transmit-enable command then sends the held byte and sets transmitter-empty again.
- R7: Command misc code 3 resets the transmitter. It disables the transmitter, clears transmit-ready and sets transmitter-empty, which discards any held byte.
- R8: A read of offset 0x0C returns the FIFO head and pops the FIFO. When the FIFO is empty the read returns 0 and does not pop.
- R9: Command bits 1:0 control the receiver: 01 enables it and 10 disables it. Command misc code 2 disables the receiver and flushes the FIFO. `rx_en_o` reports the receiver enable.
- R10: Interrupt status has three bits. Bit 0 equals transmit-ready. Bit 1 equals FIFO-full when bit 6 of the first mode byte is set, and receive-ready otherwise. Bit 2 is set by `brk_i` and cleared by command misc code 5.
- R11: `irq_o` is the OR of interrupt status ANDed with the mask written at offset 0x14. It is registered, so it changes one cycle after the change that causes it.
- R12: The command byte has three fields. Bits 6:4 hold the misc code, bits 3:2 control the transmitter and bits 1:0 control the receiver. A field value of 11, and misc codes 0, 4, 6 and 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte address; only the low 6 bits are decoded |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid after the request edge |
| baud_hi_i | input | 8 | Baud divider high byte, read only |
| baud_lo_i | input | 8 | Baud divider low byte, read only |
| tx_data_o | output | 8 | Byte handed to the serialiser |
| tx_strobe_o | output | 1 | One-cycle send strobe |
| rxf_data_i | input | 8 | Receive FIFO head |
| rxf_empty_i | input | 1 | Receive FIFO empty |
| rxf_full_i | input | 1 | Receive FIFO full |
| rxf_pop_o | output | 1 | Pop request; the FIFO advances at the same edge |
| rxf_flush_o | output | 1 | One-cycle FIFO flush |
| rx_en_o | output | 1 | Receiver enable; the FIFO accepts data only while it is high |
| brk_i | input | 1 | Break-change event pulse |
| irq_o | output | 1 | Masked interrupt |

## Verification
The transmit path is driven in three states: enabled, disabled with a held byte, and disabled with the held byte then replaced. These show whether a byte is sent at once, held, overwritten, or dropped by a transmitter reset. The receive path is filled to full, drained past empty, and written while the receiver is disabled or being reset. This separates the pop, the zero-on-empty read and the flush. Mode-byte bit 6 is toggled at half fill and at full fill to show which status flag drives the receive interrupt. Reserved and no-op command codes are sent between reads of status to show that they change nothing.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int BYTE_W    = 8;
  localparam int WIN_BYTES = 64;
  localparam int OFF_W     = $clog2(WIN_BYTES);

  localparam logic [OFF_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CMD   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_DATA  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_IPC   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_INT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_BD_HI = 6'h18;
  localparam logic [OFF_W-1:0] OFF_BD_LO = 6'h1C;

  // status bit positions
  localparam int ST_RX_RDY = 0;
  localparam int ST_FULL   = 1;
  localparam int ST_TX_RDY = 2;
  localparam int ST_TX_EMP = 3;

  // interrupt status bit positions
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;

  // first mode byte: receive interrupt source select
  localparam int MR_RXSEL = 6;

  typedef enum logic [1:0] {
    EN_NOP = 2'b00,
    EN_ON  = 2'b01,
    EN_OFF = 2'b10,
    EN_RSV = 2'b11
  } en_fld_e;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_RST_PTR = 3'd1,
    MISC_RST_RX  = 3'd2,
    MISC_RST_TX  = 3'd3,
    MISC_RST_ERR = 3'd4,
    MISC_CLR_BRK = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef struct packed {
    logic rst_ptr;
    logic rst_rx;
    logic rst_tx;
    logic clr_brk;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_regs_pkg::*;
(
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_t              cmd_o
);
  misc_e   misc;
  en_fld_e tx_f;
  en_fld_e rx_f;

  assign misc = misc_e'(cmd_i[6:4]);
  assign tx_f = en_fld_e'(cmd_i[3:2]);
  assign rx_f = en_fld_e'(cmd_i[1:0]);

  always_comb begin
    cmd_o = '0;
    if (valid_i) begin
      cmd_o.rst_ptr = (misc == MISC_RST_PTR);
      cmd_o.rst_rx  = (misc == MISC_RST_RX);
      cmd_o.rst_tx  = (misc == MISC_RST_TX);
      cmd_o.clr_brk = (misc == MISC_CLR_BRK);
      cmd_o.tx_on   = (tx_f == EN_ON);
      cmd_o.tx_off  = (tx_f == EN_OFF);
      cmd_o.rx_on   = (rx_f == EN_ON);
      cmd_o.rx_off  = (rx_f == EN_OFF);
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  input  logic              tb_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              tx_en_o,
  output logic              tx_emp_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_strobe_o
);
  logic              en_q, en_n;
  logic              emp_q, emp_n;
  logic [BYTE_W-1:0] tb_q, tb_n;
  logic [BYTE_W-1:0] dat_q, dat_n;
  logic              stb_n;

  // misc field first, then the transmitter field; data writes cannot coincide
  always_comb begin
    en_n  = en_q;
    emp_n = emp_q;
    tb_n  = tb_q;
    dat_n = dat_q;
    stb_n = 1'b0;
    if (cmd_i.rst_tx) begin
      en_n  = 1'b0;
      emp_n = 1'b1;
    end
    if (cmd_i.tx_on) begin
      en_n = 1'b1;
      if (!emp_n) begin
        stb_n = 1'b1;
        dat_n = tb_q;
        emp_n = 1'b1;
      end
    end
    if (cmd_i.tx_off) en_n = 1'b0;
    if (tb_wr_i) begin
      tb_n = wdata_i;
      if (en_q) begin
        stb_n = 1'b1;
        dat_n = wdata_i;
      end else begin
        emp_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      emp_q       <= 1'b1;
      tb_q        <= '0;
      dat_q       <= '0;
      tx_strobe_o <= 1'b0;
    end else begin
      en_q        <= en_n;
      emp_q       <= emp_n;
      tb_q        <= tb_n;
      dat_q       <= dat_n;
      tx_strobe_o <= stb_n;
    end
  end

  assign tx_en_o   = en_q;
  assign tx_emp_o  = emp_q;
  assign tx_data_o = dat_q;

  p_strobe_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |-> en_q);
  p_strobe_leaves_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |-> emp_q);
  p_rst_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.rst_tx && !cmd_i.tx_on) |=> (!en_q && emp_q && !tx_strobe_o));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              imr_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              brk_i,
  input  logic              clr_brk_i,
  input  logic              tx_rdy_i,
  input  logic              rx_rdy_i,
  input  logic              rx_full_i,
  input  logic              rx_sel_i,
  output logic [BYTE_W-1:0] isr_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] imr_q;
  logic              brk_q;

  always_comb begin
    isr_o         = '0;
    isr_o[IS_TX]  = tx_rdy_i;
    isr_o[IS_RX]  = rx_sel_i ? rx_full_i : rx_rdy_i;
    isr_o[IS_BRK] = brk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '0;
      brk_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (imr_wr_i) imr_q <= wdata_i;
      // a new event wins over a clear in the same cycle
      if (brk_i)          brk_q <= 1'b1;
      else if (clr_brk_i) brk_q <= 1'b0;
      irq_o <= |(isr_o & imr_q);
    end
  end

  p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q == '0) |=> !irq_o);
  p_brk_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_brk_i && !brk_i) |=> !isr_o[IS_BRK]);
  p_brk_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> isr_o[IS_BRK]);
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [7:0]        baud_hi_i,
  input  logic [7:0]        baud_lo_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_strobe_o,
  input  logic [7:0]        rxf_data_i,
  input  logic              rxf_empty_i,
  input  logic              rxf_full_i,
  output logic              rxf_pop_o,
  output logic              rxf_flush_o,
  output logic              rx_en_o,
  input  logic              brk_i,
  output logic              irq_o
);
  localparam int NUM_MR = 2;

  logic [OFF_W-1:0]  off;
  logic              wr, rd;
  cmd_t              cmd;
  logic [BYTE_W-1:0] mr_q [NUM_MR];
  logic              ptr_q;
  logic              rx_en_q;
  logic              tx_en, tx_emp;
  logic [BYTE_W-1:0] isr;
  logic [BYTE_W-1:0] stat;
  logic [BYTE_W-1:0] rd_n;

  assign off = addr_i[OFF_W-1:0];
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  uart_cmd_dec u_cmd_dec (
    .valid_i (wr && (off == OFF_CMD)),
    .cmd_i   (wdata_i),
    .cmd_o   (cmd)
  );

  uart_tx_ctrl u_tx_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .tb_wr_i     (wr && (off == OFF_DATA)),
    .wdata_i     (wdata_i),
    .tx_en_o     (tx_en),
    .tx_emp_o    (tx_emp),
    .tx_data_o   (tx_data_o),
    .tx_strobe_o (tx_strobe_o)
  );

  uart_irq_ctrl u_irq_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .imr_wr_i  (wr && (off == OFF_INT)),
    .wdata_i   (wdata_i),
    .brk_i     (brk_i),
    .clr_brk_i (cmd.clr_brk),
    .tx_rdy_i  (tx_en),
    .rx_rdy_i  (!rxf_empty_i),
    .rx_full_i (rxf_full_i),
    .rx_sel_i  (mr_q[0][MR_RXSEL]),
    .isr_o     (isr),
    .irq_o     (irq_o)
  );

  // mode bytes behind an auto-advancing pointer
  for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         mr_q[g] <= '0;
      else if (wr && (off == OFF_MODE) && (ptr_q == 1'(g))) mr_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ptr_q <= 1'b0;
    else if (wr && (off == OFF_MODE)) ptr_q <= 1'b1;
    else if (cmd.rst_ptr)             ptr_q <= 1'b0;
  end

  // receiver: reset first, then the enable field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q     <= 1'b0;
      rxf_flush_o <= 1'b0;
    end else begin
      rxf_flush_o <= cmd.rst_rx;
      if (cmd.rx_on)                     rx_en_q <= 1'b1;
      else if (cmd.rx_off || cmd.rst_rx) rx_en_q <= 1'b0;
    end
  end
  assign rx_en_o = rx_en_q;

  assign rxf_pop_o = rd && (off == OFF_DATA) && !rxf_empty_i;

  always_comb begin
    stat            = '0;
    stat[ST_RX_RDY] = !rxf_empty_i;
    stat[ST_FULL]   = rxf_full_i;
    stat[ST_TX_RDY] = tx_en;
    stat[ST_TX_EMP] = tx_emp;
  end

  always_comb begin
    unique case (off)
      OFF_MODE:  rd_n = mr_q[ptr_q];
      OFF_STAT:  rd_n = stat;
      OFF_DATA:  rd_n = rxf_empty_i ? '0 : rxf_data_i;
      OFF_INT:   rd_n = isr;
      OFF_BD_HI: rd_n = baud_hi_i;
      OFF_BD_LO: rd_n = baud_lo_i;
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_n;
  end

  p_ptr_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (off == OFF_MODE)) |=> ptr_q);
  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_pop_o |-> !rxf_empty_i);
  p_stat_hi_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (off == OFF_STAT)) |=> (rdata_o[7:4] == 4'h0));
  p_rst_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.rst_rx && !cmd.rx_on) |=> (!rx_en_o && rxf_flush_o));
endmodule

// File: tb/uart_regs_bench.sv
module uart_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req = 1'b0, we = 1'b0, brk = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, tx_data;
  logic       tx_strobe, pop, flush, rx_en, irq;
  logic [7:0] baud_hi = 8'hA5, baud_lo = 8'h3C;
  logic [7:0] f_head;
  logic       f_empty, f_full;

  int checks = 0, fails = 0;
  logic [7:0] fifo_q[$];
  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];
  logic       rd_seen = 1'b0;
  logic       s_pop, s_flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regs u_uart_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .baud_hi_i(baud_hi), .baud_lo_i(baud_lo),
    .tx_data_o(tx_data), .tx_strobe_o(tx_strobe), .rxf_data_i(f_head),
    .rxf_empty_i(f_empty), .rxf_full_i(f_full), .rxf_pop_o(pop),
    .rxf_flush_o(flush), .rx_en_o(rx_en), .brk_i(brk), .irq_o(irq)
  );

  function automatic void refresh();
    f_empty = (fifo_q.size() == 0);
    f_full  = (fifo_q.size() == 4);
    f_head  = f_empty ? 8'h00 : fifo_q[0];
  endfunction
  initial refresh();

  // companion FIFO model, 4 deep
  always @(posedge clk) begin
    s_pop = pop; s_flush = flush;
    #1;
    if (s_flush) fifo_q.delete();
    else if (s_pop && fifo_q.size() > 0) void'(fifo_q.pop_front());
    refresh();
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // read scoreboard monitor
  always @(posedge clk) rd_seen <= req && !we;
  always @(negedge clk) begin
    if (rd_seen && rd_exp_q.size() > 0)
      check(rdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
  end

  // transmit scoreboard monitor
  always @(negedge clk) begin
    if (tx_strobe === 1'b1) begin
      if (tx_exp_q.size() == 0) check(tx_data, 8'hxx, "R5/R6/R7 unexpected strobe");
      else check(tx_data, tx_exp_q.pop_front(), "R5/R6 tx byte");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    if (rx_en && fifo_q.size() < 4) fifo_q.push_back(b);
    refresh();
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    check({7'd0, irq}, {7'd0, exp}, tag);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd(8'h04, 8'h08, "R1 status");
    rd(8'h00, 8'h00, "R1 mode");
    rd(8'h14, 8'h00, "R1 isr");
    check({6'd0, irq, rx_en}, 8'h00, "R1 irq/rx_en");
    // R2 mode pointer
    wr(8'h00, 8'h13); wr(8'h00, 8'h27);
    rd(8'h00, 8'h27, "R2 second mode byte");
    wr(8'h00, 8'h5A);
    rd(8'h00, 8'h5A, "R2 pointer stays on second");
    wr(8'h08, 8'h10);
    rd(8'h00, 8'h13, "R2 pointer reset");
    // R3 decode
    wr(8'h04, 8'hFF);
    rd(8'h04, 8'h08, "R3 status write ignored");
    rd(8'h18, 8'hA5, "R3 baud hi");
    rd(8'h1C, 8'h3C, "R3 baud lo");
    rd(8'h10, 8'h00, "R3 ipc zero");
    rd(8'h08, 8'h00, "R3 cmd reads zero");
    rd(8'h24, 8'h00, "R3 unmapped");
    rd(8'h44, 8'h08, "R3 alias status");
    rd(8'hD8, 8'hA5, "R3 alias baud");
    // R12 no-op fields
    wr(8'h08, 8'h0C); wr(8'h08, 8'h40); wr(8'h08, 8'h70); wr(8'h08, 8'h03);
    rd(8'h04, 8'h08, "R12 no-op commands");
    check({7'd0, rx_en}, 8'h00, "R12 rx field 11");
    // R4 R5 immediate send
    wr(8'h08, 8'h04);
    rd(8'h04, 8'h0C, "R4 tx ready follows enable");
    tx_exp_q.push_back(8'h55); wr(8'h0C, 8'h55);
    tx_exp_q.push_back(8'hAA); wr(8'h0C, 8'hAA);
    rd(8'h04, 8'h0C, "R5 empty stays set");
    // R6 held byte
    wr(8'h08, 8'h08);
    rd(8'h04, 8'h08, "R6 disabled");
    wr(8'h0C, 8'h77);
    rd(8'h04, 8'h00, "R6 empty cleared");
    wr(8'h0C, 8'h99);
    tx_exp_q.push_back(8'h99); wr(8'h08, 8'h04);
    rd(8'h04, 8'h0C, "R6 sent on enable");
    // R7 reset transmitter
    wr(8'h08, 8'h08); wr(8'h0C, 8'h31);
    wr(8'h08, 8'h30);
    rd(8'h04, 8'h08, "R7 reset discards");
    wr(8'h08, 8'h04);
    rd(8'h04, 8'h0C, "R7 no send after reset");
    wr(8'h08, 8'h30);
    rd(8'h04, 8'h08, "R7 reset clears ready");
    // R9 R8 receive
    wr(8'h08, 8'h01);
    check({7'd0, rx_en}, 8'h01, "R9 rx enable");
    push(8'h11); push(8'h22);
    rd(8'h04, 8'h09, "R4 rx ready");
    push(8'h33); push(8'h44); push(8'h55);
    rd(8'h04, 8'h0B, "R4 fifo full");
    rd(8'h0C, 8'h11, "R8 pop 1"); rd(8'h0C, 8'h22, "R8 pop 2");
    rd(8'h0C, 8'h33, "R8 pop 3"); rd(8'h0C, 8'h44, "R8 pop 4");
    rd(8'h0C, 8'h00, "R8 empty reads zero");
    rd(8'h04, 8'h08, "R8 drained");
    wr(8'h08, 8'h02);
    push(8'h66);
    rd(8'h04, 8'h08, "R9 disabled drops input");
    wr(8'h08, 8'h01); push(8'h66);
    wr(8'h08, 8'h20);
    check({7'd0, rx_en}, 8'h00, "R9 reset clears enable");
    rd(8'h04, 8'h08, "R9 flush");
    rd(8'h0C, 8'h00, "R9 flushed read");
    // R10 R11 interrupts
    wr(8'h14, 8'h01); irq_chk(1'b0, "R11 masked tx idle");
    wr(8'h08, 8'h04);
    rd(8'h14, 8'h01, "R10 tx int");
    irq_chk(1'b1, "R11 tx irq");
    wr(8'h14, 8'h00); irq_chk(1'b0, "R11 mask off");
    wr(8'h14, 8'h02); wr(8'h08, 8'h01);
    push(8'h71); irq_chk(1'b1, "R11 rx ready irq");
    rd(8'h14, 8'h03, "R10 rx int on ready");
    wr(8'h08, 8'h10); wr(8'h00, 8'h53);
    rd(8'h14, 8'h01, "R10 rx int needs full");
    irq_chk(1'b0, "R11 rx int not full");
    push(8'h72); push(8'h73); push(8'h74); irq_chk(1'b1, "R11 full irq");
    rd(8'h14, 8'h03, "R10 rx int on full");
    rd(8'h0C, 8'h71, "R8 pop a"); rd(8'h0C, 8'h72, "R8 pop b");
    rd(8'h0C, 8'h73, "R8 pop c"); rd(8'h0C, 8'h74, "R8 pop d");
    @(negedge clk); brk = 1; @(negedge clk); brk = 0;
    rd(8'h14, 8'h05, "R10 break set");
    wr(8'h14, 8'h04); irq_chk(1'b1, "R11 break irq");
    wr(8'h08, 8'h50);
    rd(8'h14, 8'h01, "R10 break cleared");
    irq_chk(1'b0, "R11 break irq cleared");
    repeat (3) @(negedge clk);
    checks++;
    if (tx_exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5/R6 missing tx: got %0d pending expected 0", tx_exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule